// File: doc/BRIEF.md
# Stall-on-Full Debug Capture Engine

This block is the capture engine of an on-chip logic analyzer built into an emulated design. The probe bus is split into equal data groups. A runtime select input picks the group that is recorded. A second select input picks which of several design clock enables marks a sample instant. A sample instant stores the selected group only when the qualification input is high and the instant falls inside a programmed window. The window is given as first and last sample index, counted from the most recent arm.

Stored samples go into a local circular buffer. Before a trigger, the buffer keeps a rolling history: once it is full, each new sample replaces the oldest entry. After a trigger, the buffer fills forward only. The contents become visible to the host on a valid/ready drain port. When the post-trigger buffer fills, the block raises a stall request that the environment uses to freeze the design clocks, so no sample is ever lost. Draining one entry frees space, and the stall drops one cycle later.

Top module: `capture_stall_buffer`

## Requirements
- R1: After reset, `stall_o`, `drain_valid_o`, `sts_armed_o`, `sts_triggered_o` and `sts_full_o` are 0 and `sts_count_o` is 0.
- R2: A stored sample equals bits `[g*DATA_W +: DATA_W]` of `probe_i`, where g is the value of `grp_sel_i` in the sampling cycle.
- R3: A sample instant is a cycle where the block is armed and `clken_i[clken_sel_i]` is 1. A pulse on any other enable bit stores nothing and does not advance the window index.
- R4: A sample instant with `qual_i` low stores nothing, but it still advances the window index.
- R5: Sample instants are numbered from 0 after each arm. A sample is stored only when `win_first_i <= index <= win_last_i`.
- R6: Before a trigger, the buffer holds at most DEPTH entries. Each new sample into a full buffer discards the oldest entry. `stall_o` and `drain_valid_o` stay 0 during this phase.
- R7: A `trig_i` pulse while armed releases the buffer. From then on, `drain_valid_o` is 1 whenever the buffer is non-empty, and entries come out oldest first.
- R8: After the trigger, once `sts_count_o` reaches DEPTH, `stall_o` and `sts_full_o` are 1 in that same cycle and no further sample is written.
- R9: `stall_o` remains 1 for exactly one cycle after the occupancy drops below DEPTH, then falls.
- R10: An entry is removed only on a cycle with `drain_valid_o` and `drain_ready_i` both high. While valid is high and ready is low, `drain_data_o` and `drain_valid_o` hold their values.
- R11: An `arm_i` pulse empties the buffer, clears the window index and the released state, and sets `sts_armed_o`.
- R12: `sts_count_o` reports the current number of buffered entries. `sts_triggered_o` reports the released phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| probe_i | input | NUM_GROUPS*DATA_W | All probe groups, concatenated |
| grp_sel_i | input | $clog2(NUM_GROUPS) | Group recorded at each sample |
| clken_i | input | NUM_CLKEN | Candidate design clock enables |
| clken_sel_i | input | $clog2(NUM_CLKEN) | Enable that marks sample instants |
| qual_i | input | 1 | Sample qualifier |
| win_first_i | input | IDX_W | First stored sample index |
| win_last_i | input | IDX_W | Last stored sample index |
| arm_i | input | 1 | Arm pulse (clears capture state) |
| trig_i | input | 1 | Trigger pulse |
| stall_o | output | 1 | Request to freeze design clocks |
| drain_valid_o | output | 1 | Drain entry available |
| drain_ready_i | input | 1 | Host accepts drain entry |
| drain_data_o | output | DATA_W | Oldest buffered sample |
| sts_armed_o | output | 1 | Capture armed |
| sts_triggered_o | output | 1 | Buffer released to host |
| sts_full_o | output | 1 | Buffer holds DEPTH entries |
| sts_count_o | output | $clog2(DEPTH+1) | Buffered entry count |

## Verification
The assertions assume that the environment honours `stall_o`: no enable on the selected `clken_i` bit arrives while the stall is high. They also assume that `arm_i` and sample instants never share a cycle. The drain port follows valid/ready rules: data must stay put while valid is high and ready is low. The stimulus stops offering sample instants as soon as the post-trigger fill reaches DEPTH. It resumes only after draining, and it always issues the arm pulse in a cycle of its own.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HIST = 2'd1,
    PH_REL  = 2'd2
  } cap_phase_e;
endpackage

// File: rtl/cap_select.sv
module cap_select #(
  parameter int NUM_GROUPS = 16,
  parameter int DATA_W     = 8,
  parameter int NUM_CLKEN  = 4,
  parameter int IDX_W      = 16,
  localparam int GSEL_W    = $clog2(NUM_GROUPS),
  localparam int ESEL_W    = $clog2(NUM_CLKEN)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         armed_i,
  input  logic                         arm_i,
  input  logic [NUM_GROUPS*DATA_W-1:0] probe_i,
  input  logic [GSEL_W-1:0]            grp_sel_i,
  input  logic [NUM_CLKEN-1:0]         clken_i,
  input  logic [ESEL_W-1:0]            clken_sel_i,
  input  logic                         qual_i,
  input  logic [IDX_W-1:0]             win_first_i,
  input  logic [IDX_W-1:0]             win_last_i,
  output logic                         smp_valid_o,
  output logic [DATA_W-1:0]            smp_data_o
);
  logic [DATA_W-1:0] grp_arr [NUM_GROUPS];
  logic [IDX_W-1:0]  idx_q;
  logic              instant;
  logic              in_win;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    assign grp_arr[g] = probe_i[g*DATA_W +: DATA_W];
  end

  assign instant    = armed_i && !arm_i && clken_i[clken_sel_i];
  assign in_win     = (idx_q >= win_first_i) && (idx_q <= win_last_i);
  assign smp_valid_o = instant && qual_i && in_win;
  assign smp_data_o  = grp_arr[grp_sel_i];

  // sample index since arm, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          idx_q <= '0;
    else if (arm_i)                      idx_q <= '0;
    else if (instant && idx_q != '1)     idx_q <= idx_q + 1'b1;
  end

  // R5: a stored sample always carries an index inside the window
  a_r5_window_index: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid_o |=> (($past(idx_q) >= win_first_i) || !$stable(win_first_i)));
endmodule

// File: rtl/cap_ring.sv
module cap_ring #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 1024,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH+1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              overwrite_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              full_o,
  output logic              empty_o
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wptr_q, rptr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              do_wr, do_rd, drop_old;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o   = (cnt_q == CNT_W'(DEPTH));
  assign empty_o  = (cnt_q == '0);
  assign do_wr    = wr_i && (!full_o || overwrite_i);
  assign drop_old = wr_i && full_o && overwrite_i;
  assign do_rd    = rd_i && !empty_o;
  assign count_o  = cnt_q;
  assign rd_data_o = mem[rptr_q];

  always_ff @(posedge clk) begin
    if (do_wr && !clr_i) mem[wptr_q] <= wr_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_wr)             wptr_q <= step(wptr_q);
      if (do_rd || drop_old) rptr_q <= step(rptr_q);
      cnt_q <= cnt_q + CNT_W'(do_wr) - CNT_W'(do_rd) - CNT_W'(drop_old);
    end
  end

  // R8: occupancy never passes the buffer depth
  a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count_o <= CNT_W'(DEPTH));
  // R8: in forward-fill mode a full buffer accepts no write
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && !overwrite_i && !rd_i && !clr_i) |=> full_o && $stable(count_o));
endmodule

// File: rtl/cap_ctrl.sv
module cap_ctrl
  import cap_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic trig_i,
  input  logic full_i,
  input  logic empty_i,
  input  logic drain_ready_i,
  output logic armed_o,
  output logic released_o,
  output logic overwrite_o,
  output logic stall_o,
  output logic drain_valid_o,
  output logic pop_o
);
  cap_phase_e phase_q;
  logic       hold_q;
  logic       full_rel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               phase_q <= PH_IDLE;
    else if (arm_i)                           phase_q <= PH_HIST;
    else if (trig_i && phase_q == PH_HIST)    phase_q <= PH_REL;
  end

  assign armed_o     = (phase_q != PH_IDLE);
  assign released_o  = (phase_q == PH_REL);
  assign overwrite_o = !released_o;
  assign full_rel    = released_o && full_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hold_q <= 1'b0;
    else if (arm_i) hold_q <= 1'b0;
    else            hold_q <= full_rel;
  end

  assign stall_o       = full_rel || hold_q;
  assign drain_valid_o = released_o && !empty_i;
  assign pop_o         = drain_valid_o && drain_ready_i;

  // R6: history phase never requests a stall
  a_r6_no_hist_stall: assert property (@(posedge clk) disable iff (!rst_n)
    !released_o |-> !stall_o);
  // R9: two non-full cycles in a row mean the stall has dropped
  a_r9_stall_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_rel && !$past(full_rel)) |-> !stall_o);
  // R10: an offered entry stays offered until taken
  a_r10_valid_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_valid_o && !drain_ready_i && !arm_i) |=> drain_valid_o);
endmodule

// File: rtl/capture_stall_buffer.sv
module capture_stall_buffer #(
  parameter int NUM_GROUPS = 16,
  parameter int DATA_W     = 8,
  parameter int NUM_CLKEN  = 4,
  parameter int IDX_W      = 16,
  parameter int DEPTH      = 1024,
  localparam int GSEL_W    = $clog2(NUM_GROUPS),
  localparam int ESEL_W    = $clog2(NUM_CLKEN),
  localparam int CNT_W     = $clog2(DEPTH+1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_GROUPS*DATA_W-1:0] probe_i,
  input  logic [GSEL_W-1:0]            grp_sel_i,
  input  logic [NUM_CLKEN-1:0]         clken_i,
  input  logic [ESEL_W-1:0]            clken_sel_i,
  input  logic                         qual_i,
  input  logic [IDX_W-1:0]             win_first_i,
  input  logic [IDX_W-1:0]             win_last_i,
  input  logic                         arm_i,
  input  logic                         trig_i,
  output logic                         stall_o,
  output logic                         drain_valid_o,
  input  logic                         drain_ready_i,
  output logic [DATA_W-1:0]            drain_data_o,
  output logic                         sts_armed_o,
  output logic                         sts_triggered_o,
  output logic                         sts_full_o,
  output logic [CNT_W-1:0]             sts_count_o
);
  logic              armed, released, overwrite, pop, full, empty, smp_valid;
  logic [DATA_W-1:0] smp_data;

  cap_select #(
    .NUM_GROUPS(NUM_GROUPS), .DATA_W(DATA_W), .NUM_CLKEN(NUM_CLKEN), .IDX_W(IDX_W)
  ) u_select (
    .clk(clk), .rst_n(rst_n), .armed_i(armed), .arm_i(arm_i),
    .probe_i(probe_i), .grp_sel_i(grp_sel_i), .clken_i(clken_i),
    .clken_sel_i(clken_sel_i), .qual_i(qual_i),
    .win_first_i(win_first_i), .win_last_i(win_last_i),
    .smp_valid_o(smp_valid), .smp_data_o(smp_data)
  );

  cap_ring #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ring (
    .clk(clk), .rst_n(rst_n), .clr_i(arm_i),
    .wr_i(smp_valid), .wr_data_i(smp_data), .overwrite_i(overwrite),
    .rd_i(pop), .rd_data_o(drain_data_o), .count_o(sts_count_o),
    .full_o(full), .empty_o(empty)
  );

  cap_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .trig_i(trig_i),
    .full_i(full), .empty_i(empty), .drain_ready_i(drain_ready_i),
    .armed_o(armed), .released_o(released), .overwrite_o(overwrite),
    .stall_o(stall_o), .drain_valid_o(drain_valid_o), .pop_o(pop)
  );

  assign sts_armed_o     = armed;
  assign sts_triggered_o = released;
  assign sts_full_o      = full;

  // R10: data under back-pressure does not change
  a_r10_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_valid_o && !drain_ready_i && !arm_i) |=> $stable(drain_data_o));
  // R8: the stall covers every released, full cycle
  a_r8_stall_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_triggered_o && sts_full_o) |-> stall_o);
endmodule

// File: tb/capture_stall_buffer_tb.sv
module capture_stall_buffer_tb;
  localparam int NG = 16, DW = 8, NE = 4, IW = 16, DEPTH = 1024;

  logic clk = 0, rst_n = 0;
  logic [NG*DW-1:0] probe = '0;
  logic [3:0]  grp_sel = '0;
  logic [NE-1:0] clken = '0;
  logic [1:0]  clken_sel = '0;
  logic        qual = 0, arm = 0, trig = 0, dready = 0;
  logic [IW-1:0] wfirst = '0, wlast = '1;
  logic        stall, dvalid, armed_s, trig_s, full_s;
  logic [DW-1:0] ddata;
  logic [10:0] count_s;

  int n_run = 0, n_fail = 0;
  logic [DW-1:0] exp_q[$];
  int  idx_m = 0;
  bit  trig_m = 0;

  always #2 clk = ~clk;

  capture_stall_buffer u_dut (
    .clk(clk), .rst_n(rst_n), .probe_i(probe), .grp_sel_i(grp_sel),
    .clken_i(clken), .clken_sel_i(clken_sel), .qual_i(qual),
    .win_first_i(wfirst), .win_last_i(wlast), .arm_i(arm), .trig_i(trig),
    .stall_o(stall), .drain_valid_o(dvalid), .drain_ready_i(dready),
    .drain_data_o(ddata), .sts_armed_o(armed_s), .sts_triggered_o(trig_s),
    .sts_full_o(full_s), .sts_count_o(count_s)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // scoreboard monitor: each accepted drain beat is compared in order
  always @(negedge clk) begin
    if (rst_n && dvalid && dready) begin
      if (exp_q.size() == 0) check(0, "R7 unexpected drain beat", ddata, -1);
      else begin
        logic [DW-1:0] e;
        e = exp_q.pop_front();
        check(ddata === e, "R2/R7 drain order and data", ddata, e);
      end
    end
  end

  // driver: offers one cycle of stimulus and pushes the expected item
  task automatic tick(input int g, input logic [DW-1:0] d, input bit q, input int en);
    for (int k = 0; k < NG; k++)
      probe[k*DW +: DW] = (k == g) ? d : (d ^ 8'hA5 ^ 8'(k));
    grp_sel = 4'(g);
    clken = NE'(1) << en;
    qual = q;
    if (en == int'(clken_sel)) begin
      if (q && idx_m >= int'(wfirst) && idx_m <= int'(wlast)) begin
        exp_q.push_back(d);
        if (!trig_m && exp_q.size() > DEPTH) void'(exp_q.pop_front());
      end
      idx_m++;
    end
    @(posedge clk); #1;
    clken = '0; qual = 0;
  endtask

  task automatic do_arm();
    arm = 1; @(posedge clk); #1; arm = 0;
    idx_m = 0; trig_m = 0; exp_q.delete();
  endtask

  task automatic do_trig();
    trig = 1; @(posedge clk); #1; trig = 0; trig_m = 1;
  endtask

  task automatic drain_all();
    dready = 1;
    while (count_s != 0) @(negedge clk);
    @(posedge clk); #1; dready = 0;
    check(exp_q.size() == 0, "R7 all expected entries drained", exp_q.size(), 0);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    @(negedge clk);
    check(!stall && !dvalid && !armed_s && !trig_s && !full_s && count_s == 0,
          "R1 reset state", {stall, dvalid, armed_s, trig_s, full_s}, 0);
    rst_n = 1;
    @(posedge clk); #1;

    // test A: group select, enable select, qualification, hold under back-pressure
    clken_sel = 2'd1;
    do_arm();
    @(negedge clk); check(armed_s == 1, "R11 armed after arm", armed_s, 1);
    @(posedge clk); #1;
    do_trig();
    tick(0, 8'h11, 1, 1);
    tick(5, 8'h22, 1, 1);
    tick(15, 8'h33, 0, 1);   // R4 unqualified
    tick(3, 8'h44, 1, 0);    // R3 other enable
    tick(9, 8'h55, 1, 1);
    clken_sel = 2'd2;
    tick(1, 8'h66, 1, 2);    // R3 enable re-selected at runtime
    tick(2, 8'h77, 1, 1);    // R3 old enable now ignored
    @(negedge clk);
    check(count_s == 4, "R12 count after mixed ticks", count_s, 4);
    check(trig_s == 1, "R12 triggered status", trig_s, 1);
    check(dvalid == 1 && ddata == 8'h11, "R10 first entry offered", ddata, 8'h11);
    @(negedge clk);
    check(dvalid == 1 && ddata == 8'h11, "R10 data held while not ready", ddata, 8'h11);
    @(posedge clk); #1;
    drain_all();

    // test B: window
    clken_sel = 2'd0; wfirst = 16'd3; wlast = 16'd6;
    do_arm(); do_trig();
    for (int i = 0; i < 10; i++) tick(i, 8'(8'h80 + i), i != 4, 0);
    @(negedge clk);
    check(count_s == 3, "R5 window keeps indices 3,5,6", count_s, 3);
    @(posedge clk); #1;
    drain_all();

    // test C: pre-trigger history wraps, no stall, no drain
    wfirst = '0; wlast = '1;
    do_arm();
    dready = 1;
    for (int i = 0; i < DEPTH + 5; i++) tick(i % NG, 8'(i), 1, 0);
    @(negedge clk);
    check(count_s == DEPTH, "R6 history capped at depth", count_s, DEPTH);
    check(stall == 0, "R6 no stall before trigger", stall, 0);
    check(dvalid == 0, "R6 no drain before trigger", dvalid, 0);
    check(trig_s == 0, "R12 not triggered yet", trig_s, 0);
    dready = 0;
    @(posedge clk); #1;
    do_trig();
    drain_all();   // oldest five were overwritten

    // test D: post-trigger fill stalls, release timing
    do_arm(); do_trig();
    for (int i = 0; i < DEPTH; i++) tick(i % NG, 8'(i) ^ 8'h3C, 1, 0);
    @(negedge clk);
    check(stall == 1, "R8 stall at full", stall, 1);
    check(full_s == 1 && count_s == DEPTH, "R8 full status", count_s, DEPTH);
    @(posedge clk); #1;
    dready = 1;
    @(posedge clk); #1;
    dready = 0;
    @(negedge clk);
    check(count_s == DEPTH - 1, "R10 one entry popped", count_s, DEPTH - 1);
    check(stall == 1, "R9 stall held one cycle", stall, 1);
    @(negedge clk);
    check(stall == 0, "R9 stall released", stall, 0);
    @(posedge clk); #1;
    drain_all();

    // test E: arm clears everything
    do_arm(); do_trig();
    tick(0, 8'hE1, 1, 0); tick(1, 8'hE2, 1, 0); tick(2, 8'hE3, 1, 0);
    do_arm();
    @(negedge clk);
    check(count_s == 0 && trig_s == 0 && dvalid == 0 && armed_s == 1,
          "R11 arm clears state", count_s, 0);
    @(posedge clk); #1;
    do_trig();
    tick(4, 8'hF0, 1, 0);  // index restarts at 0, in window
    @(negedge clk);
    check(count_s == 1, "R11 index restarted", count_s, 1);
    @(posedge clk); #1;
    drain_all();

    finish_run();
  end
endmodule